// File: doc/BRIEF.md
# Footprint-Aware Miss Resolution Controller

This controller settles a single memory access after it has been looked up in a translation buffer that maps virtual pages straight to frames of an in-package DRAM cache. No cache tag is checked anywhere. A page held in the cache is divided into sub-blocks. The buffer entry for the page holds two vectors with one bit per sub-block: a valid vector, which marks the sub-blocks present in the frame, and a reference vector, which marks the sub-blocks touched since the page was allocated.

Every access ends in one of four outcomes:

- **Hit.** The translation buffer hit and the addressed sub-block is valid. The controller returns the cache address and marks the sub-block as referenced.
- **Block miss.** The buffer hit but the sub-block is absent. The controller reads the frame's physical page from a reverse (frame-to-physical) table, fetches that one sub-block, sets its valid bit and retries.
- **Victim hit.** The buffer missed but the walked page-table entry shows the page is already cached. The controller reinstalls the mapping and both stored vectors, then retries without a fill.
- **Page miss.** The buffer missed and the page is not cached. The controller takes a free frame and fetches only the sub-blocks the stored reference vector predicts. It then records the reverse mapping, rewrites the page-table entry, installs the translation and retries.

The controller handles one miss at a time. It keeps the request port closed from acceptance until the retried access completes as a hit.

Top module: `fpmiss_ctrl`

## Requirements
- R1: After reset, `req_ready` is high and no status pulse, walk, allocation, fill, reverse-table, install or queue push request is active.
- R2: When the buffer hits and the addressed sub-block (address bits [11:9] with default parameters) is valid, the controller pulses `st_hit` and `resp_valid` in the lookup cycle with `resp_caddr` = {frame, page offset}. In the same cycle it issues a bit update with `bs_set_v`=0, which sets the reference bit.
- R3: When the buffer hits and the addressed valid bit is clear, the controller pulses `st_blk`. It reads the reverse table for the frame and requests a fill whose mask has only the missing sub-block set. It then issues a bit update with `bs_set_v`=1 and retries the lookup.
- R4: When the buffer misses and the looked-up slot is occupied, the controller pulses `wbq_push` in the lookup cycle with the displaced entry's page number and vectors. The page-table read request starts in the following cycle.
- R5: A walked entry has bit 0 (cached) set, bits [2 +: page-number width] holding the frame, [32 +: SUB_N] holding the reference vector and [48 +: SUB_N] holding the valid vector. For such an entry the controller pulses `st_vic` and installs that frame and both vectors unchanged. It issues no fill before the retry.
- R6: When bit 0 of the walked entry is clear and bit 1 (history) is set, the controller pulses `st_page` and requests a frame from the allocator. It then fills that frame with mask = stored reference vector OR the requested sub-block.
- R7: When both bit 0 and bit 1 of the walked entry are clear (first touch), the page-fill mask is all ones.
- R8: After a page fill, the controller writes the reverse table with the frame, the physical page (entry bits [2 +: page-number width]) and the virtual page number. It then writes the page-table entry with bits 0 and 1 set, the frame, a valid vector equal to the fill mask and a zero reference vector. Finally it installs a translation with those same vectors.
- R9: `req_ready` is low from the cycle after a request is accepted until the cycle after the completing hit, and high again in that following cycle.
- R10: Each lookup or walk result raises at most one of `st_hit`, `st_blk`, `st_vic`, `st_page` in a cycle. An access that takes a miss ends with exactly one `st_hit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_va | input | VA_W | Virtual address of the access |
| lk_vpn | output | VA_W-PAGE_BITS | Page number presented to the translation buffer |
| lk_hit | input | 1 | Buffer holds a mapping for `lk_vpn` |
| lk_frame | input | FRAME_W | Cache frame of the hitting entry |
| lk_vvec | input | SUB_N | Valid vector of the hitting entry |
| lk_occ | input | 1 | Slot chosen for `lk_vpn` is occupied |
| lk_vic_vpn | input | VA_W-PAGE_BITS | Page number held in that slot |
| lk_vic_vvec | input | SUB_N | Valid vector held in that slot |
| lk_vic_rvec | input | SUB_N | Reference vector held in that slot |
| tw_valid | output | 1 | Install a translation |
| tw_vpn | output | VA_W-PAGE_BITS | Page number to install |
| tw_frame | output | FRAME_W | Frame to install |
| tw_vvec | output | SUB_N | Valid vector to install |
| tw_rvec | output | SUB_N | Reference vector to install |
| bs_valid | output | 1 | Set one bit in a buffer entry |
| bs_vpn | output | VA_W-PAGE_BITS | Page number of that entry |
| bs_sub | output | $clog2(SUB_N) | Sub-block index |
| bs_set_v | output | 1 | 1: set valid bit, 0: set reference bit |
| resp_valid | output | 1 | Access completed |
| resp_caddr | output | FRAME_W+PAGE_BITS | Cache address of the completed access |
| st_hit | output | 1 | Hit outcome pulse |
| st_blk | output | 1 | Block-miss outcome pulse |
| st_vic | output | 1 | Victim-hit outcome pulse |
| st_page | output | 1 | Page-miss outcome pulse |
| wbq_push | output | 1 | Push displaced entry to the write-back queue |
| wbq_vpn | output | VA_W-PAGE_BITS | Displaced page number |
| wbq_vvec | output | SUB_N | Displaced valid vector |
| wbq_rvec | output | SUB_N | Displaced reference vector |
| pw_req | output | 1 | Page-table access request |
| pw_we | output | 1 | 1: write entry, 0: read entry |
| pw_vpn | output | VA_W-PAGE_BITS | Page number of the entry |
| pw_wdata | output | 64 | Entry to write |
| pw_ack | input | 1 | Page-table access done |
| pw_rdata | input | 64 | Entry read |
| al_req | output | 1 | Free-frame request |
| al_ack | input | 1 | Frame granted |
| al_frame | input | FRAME_W | Granted frame |
| fl_req | output | 1 | Fill request |
| fl_ppn | output | PPN_W | Source physical page |
| fl_frame | output | FRAME_W | Destination frame |
| fl_mask | output | SUB_N | Sub-blocks to transfer |
| fl_done | input | 1 | Fill complete |
| gt_req | output | 1 | Reverse-table access request |
| gt_we | output | 1 | 1: write, 0: read |
| gt_frame | output | FRAME_W | Frame index |
| gt_wppn | output | PPN_W | Physical page to record |
| gt_wptr | output | VA_W-PAGE_BITS | Page-table entry pointer (virtual page number) to record |
| gt_ack | input | 1 | Reverse-table access done |
| gt_rppn | input | PPN_W | Physical page read |

## Verification
Some rules are checked by assertions on every cycle:

- Outcome pulses never overlap.
- A queue push is always followed by a page-table read.
- A block-miss fill carries exactly one sub-block.
- A page fill always includes the requested sub-block.
- The request port closes after a block miss and reopens after a hit.
- An install that follows a page-table rewrite carries a cleared reference vector.
- A victim hit is never followed by a fill.

Other behaviour can only be shown by the bench's scenarios, each checked against independent models of the translation buffer, page table and reverse table:

- whether the fill mask matches the stored history or the all-ones first-touch rule;
- whether the rewritten page-table entry and the reverse-table record hold the right frame, page and vectors;
- whether a victim hit restores vectors previously spilled through the queue.

// File: rtl/fpmiss_pkg.sv
package fpmiss_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_LOOK, S_WALK, S_ALLOC, S_PFILL, S_GWR,
      S_PTEW, S_INST, S_GRD, S_BFILL, S_BSET
   } fsm_e;

   localparam int PTE_W      = 64;
   localparam int CACHED_BIT = 0;
   localparam int HIST_BIT   = 1;
   localparam int PN_LSB     = 2;
   localparam int REF_LSB    = 32;
   localparam int VLD_LSB    = 48;

endpackage

// File: rtl/fpmiss_pte_codec.sv
module fpmiss_pte_codec import fpmiss_pkg::*; #(
   parameter int PN_W  = 20,
   parameter int SUB_N = 8
)(
   input  logic [PTE_W-1:0] raw,
   output logic             u_cached,
   output logic             u_hist,
   output logic [PN_W-1:0]  u_pn,
   output logic [SUB_N-1:0] u_ref,
   output logic [SUB_N-1:0] u_vld,
   input  logic [PN_W-1:0]  p_pn,
   input  logic [SUB_N-1:0] p_vld,
   output logic [PTE_W-1:0] packed_out
);

   initial begin
      assert (PN_W <= REF_LSB - PN_LSB) else $error("page number field too wide");
      assert (SUB_N <= VLD_LSB - REF_LSB) else $error("too many sub-blocks for entry");
   end

   logic unused_raw_bits;
   assign unused_raw_bits = ^raw;

   assign u_cached = raw[CACHED_BIT];
   assign u_hist   = raw[HIST_BIT];
   assign u_pn     = raw[PN_LSB +: PN_W];
   assign u_ref    = raw[REF_LSB +: SUB_N];
   assign u_vld    = raw[VLD_LSB +: SUB_N];

   always_comb begin
      packed_out                    = '0;
      packed_out[CACHED_BIT]        = 1'b1;
      packed_out[HIST_BIT]          = 1'b1;
      packed_out[PN_LSB +: PN_W]    = p_pn;
      packed_out[VLD_LSB +: SUB_N]  = p_vld;
   end

endmodule

// File: rtl/fpmiss_classify.sv
module fpmiss_classify #(
   parameter int SUB_N = 8,
   localparam int SUB_W = $clog2(SUB_N)
)(
   input  logic             look,
   input  logic             lk_hit,
   input  logic [SUB_N-1:0] lk_vvec,
   input  logic [SUB_W-1:0] sub,
   output logic [SUB_N-1:0] sub_oh,
   output logic             c_hit,
   output logic             c_blk,
   output logic             c_miss
);

   always_comb begin
      sub_oh      = '0;
      sub_oh[sub] = 1'b1;
   end

   logic present;
   assign present = |(lk_vvec & sub_oh);

   assign c_hit  = look &  lk_hit &  present;
   assign c_blk  = look &  lk_hit & ~present;
   assign c_miss = look & ~lk_hit;

endmodule

// File: rtl/fpmiss_fill_mask.sv
module fpmiss_fill_mask #(
   parameter int SUB_N      = 8,
   parameter bit FULL_FIRST = 1'b1
)(
   input  logic             hist,
   input  logic [SUB_N-1:0] ref_vec,
   input  logic [SUB_N-1:0] sub_oh,
   output logic [SUB_N-1:0] mask
);

   logic [SUB_N-1:0] base;

   generate
      if (FULL_FIRST) begin : g_full_first
         assign base = hist ? ref_vec : {SUB_N{1'b1}};
      end else begin : g_demand_first
         assign base = hist ? ref_vec : {SUB_N{1'b0}};
      end
   endgenerate

   assign mask = base | sub_oh;

endmodule

// File: rtl/fpmiss_ctrl.sv
module fpmiss_ctrl import fpmiss_pkg::*; #(
   parameter int VA_W       = 32,
   parameter int PAGE_BITS  = 12,
   parameter int SUB_N      = 8,
   parameter int FRAME_W    = 10,
   parameter int PPN_W      = 20,
   parameter bit FULL_FIRST = 1'b1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   output logic                          req_ready,
   input  logic [VA_W-1:0]               req_va,
   output logic [VA_W-PAGE_BITS-1:0]     lk_vpn,
   input  logic                          lk_hit,
   input  logic [FRAME_W-1:0]            lk_frame,
   input  logic [SUB_N-1:0]              lk_vvec,
   input  logic                          lk_occ,
   input  logic [VA_W-PAGE_BITS-1:0]     lk_vic_vpn,
   input  logic [SUB_N-1:0]              lk_vic_vvec,
   input  logic [SUB_N-1:0]              lk_vic_rvec,
   output logic                          tw_valid,
   output logic [VA_W-PAGE_BITS-1:0]     tw_vpn,
   output logic [FRAME_W-1:0]            tw_frame,
   output logic [SUB_N-1:0]              tw_vvec,
   output logic [SUB_N-1:0]              tw_rvec,
   output logic                          bs_valid,
   output logic [VA_W-PAGE_BITS-1:0]     bs_vpn,
   output logic [$clog2(SUB_N)-1:0]      bs_sub,
   output logic                          bs_set_v,
   output logic                          resp_valid,
   output logic [FRAME_W+PAGE_BITS-1:0]  resp_caddr,
   output logic                          st_hit,
   output logic                          st_blk,
   output logic                          st_vic,
   output logic                          st_page,
   output logic                          wbq_push,
   output logic [VA_W-PAGE_BITS-1:0]     wbq_vpn,
   output logic [SUB_N-1:0]              wbq_vvec,
   output logic [SUB_N-1:0]              wbq_rvec,
   output logic                          pw_req,
   output logic                          pw_we,
   output logic [VA_W-PAGE_BITS-1:0]     pw_vpn,
   output logic [63:0]                   pw_wdata,
   input  logic                          pw_ack,
   input  logic [63:0]                   pw_rdata,
   output logic                          al_req,
   input  logic                          al_ack,
   input  logic [FRAME_W-1:0]            al_frame,
   output logic                          fl_req,
   output logic [PPN_W-1:0]              fl_ppn,
   output logic [FRAME_W-1:0]            fl_frame,
   output logic [SUB_N-1:0]              fl_mask,
   input  logic                          fl_done,
   output logic                          gt_req,
   output logic                          gt_we,
   output logic [FRAME_W-1:0]            gt_frame,
   output logic [PPN_W-1:0]              gt_wppn,
   output logic [VA_W-PAGE_BITS-1:0]     gt_wptr,
   input  logic                          gt_ack,
   input  logic [PPN_W-1:0]              gt_rppn
);

   localparam int VPN_W = VA_W - PAGE_BITS;
   localparam int SUB_W = $clog2(SUB_N);
   localparam int PN_W  = (PPN_W > FRAME_W) ? PPN_W : FRAME_W;

   initial begin
      assert (SUB_N >= 2 && (1 << SUB_W) == SUB_N) else $error("SUB_N must be a power of two");
      assert (SUB_W <= PAGE_BITS) else $error("sub-block index exceeds page offset");
      assert (VA_W > PAGE_BITS) else $error("no page number bits");
   end

   fsm_e               state_q;
   logic [VPN_W-1:0]   vpn_q;
   logic [PAGE_BITS-1:0] off_q;
   logic [FRAME_W-1:0] frame_q;
   logic [PPN_W-1:0]   ppn_q;
   logic [SUB_N-1:0]   mask_q, vvec_q, rvec_q;

   logic [SUB_W-1:0]   sub;
   logic [SUB_N-1:0]   sub_oh, fill_mask;
   logic               c_hit, c_blk, c_miss;
   logic               pte_cached, pte_hist;
   logic [PN_W-1:0]    pte_pn;
   logic [SUB_N-1:0]   pte_ref, pte_vld;
   logic [63:0]        pte_new;

   assign sub = off_q[PAGE_BITS-1 -: SUB_W];

   fpmiss_classify #(.SUB_N(SUB_N)) u_cls (
      .look(state_q == S_LOOK), .lk_hit(lk_hit), .lk_vvec(lk_vvec), .sub(sub),
      .sub_oh(sub_oh), .c_hit(c_hit), .c_blk(c_blk), .c_miss(c_miss)
   );

   fpmiss_pte_codec #(.PN_W(PN_W), .SUB_N(SUB_N)) u_pte (
      .raw(pw_rdata), .u_cached(pte_cached), .u_hist(pte_hist), .u_pn(pte_pn),
      .u_ref(pte_ref), .u_vld(pte_vld), .p_pn(PN_W'(frame_q)), .p_vld(mask_q),
      .packed_out(pte_new)
   );

   fpmiss_fill_mask #(.SUB_N(SUB_N), .FULL_FIRST(FULL_FIRST)) u_mask (
      .hist(pte_hist), .ref_vec(pte_ref), .sub_oh(sub_oh), .mask(fill_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         vpn_q   <= '0;
         off_q   <= '0;
         frame_q <= '0;
         ppn_q   <= '0;
         mask_q  <= '0;
         vvec_q  <= '0;
         rvec_q  <= '0;
      end else begin
         case (state_q)
            S_IDLE: if (req_valid) begin
               vpn_q   <= req_va[VA_W-1:PAGE_BITS];
               off_q   <= req_va[PAGE_BITS-1:0];
               state_q <= S_LOOK;
            end
            S_LOOK: begin
               if (c_hit) state_q <= S_IDLE;
               else if (c_blk) begin
                  frame_q <= lk_frame;
                  state_q <= S_GRD;
               end else state_q <= S_WALK;
            end
            S_WALK: if (pw_ack) begin
               if (pte_cached) begin
                  frame_q <= pte_pn[FRAME_W-1:0];
                  vvec_q  <= pte_vld;
                  rvec_q  <= pte_ref;
                  state_q <= S_INST;
               end else begin
                  ppn_q   <= pte_pn[PPN_W-1:0];
                  mask_q  <= fill_mask;
                  state_q <= S_ALLOC;
               end
            end
            S_ALLOC: if (al_ack) begin
               frame_q <= al_frame;
               state_q <= S_PFILL;
            end
            S_PFILL: if (fl_done) state_q <= S_GWR;
            S_GWR:   if (gt_ack)  state_q <= S_PTEW;
            S_PTEW:  if (pw_ack) begin
               vvec_q  <= mask_q;
               rvec_q  <= '0;
               state_q <= S_INST;
            end
            S_INST:  state_q <= S_LOOK;
            S_GRD:   if (gt_ack) begin
               ppn_q   <= gt_rppn;
               mask_q  <= sub_oh;
               state_q <= S_BFILL;
            end
            S_BFILL: if (fl_done) state_q <= S_BSET;
            S_BSET:  state_q <= S_LOOK;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == S_IDLE);
   assign lk_vpn     = vpn_q;

   assign st_hit     = c_hit;
   assign st_blk     = c_blk;
   assign st_vic     = (state_q == S_WALK) && pw_ack &&  pte_cached;
   assign st_page    = (state_q == S_WALK) && pw_ack && !pte_cached;
   assign resp_valid = c_hit;
   assign resp_caddr = {lk_frame, off_q};

   assign wbq_push   = c_miss && lk_occ;
   assign wbq_vpn    = lk_vic_vpn;
   assign wbq_vvec   = lk_vic_vvec;
   assign wbq_rvec   = lk_vic_rvec;

   assign pw_req     = (state_q == S_WALK) || (state_q == S_PTEW);
   assign pw_we      = (state_q == S_PTEW);
   assign pw_vpn     = vpn_q;
   assign pw_wdata   = pte_new;

   assign al_req     = (state_q == S_ALLOC);

   assign fl_req     = (state_q == S_PFILL) || (state_q == S_BFILL);
   assign fl_ppn     = ppn_q;
   assign fl_frame   = frame_q;
   assign fl_mask    = mask_q;

   assign gt_req     = (state_q == S_GWR) || (state_q == S_GRD);
   assign gt_we      = (state_q == S_GWR);
   assign gt_frame   = frame_q;
   assign gt_wppn    = ppn_q;
   assign gt_wptr    = vpn_q;

   assign tw_valid   = (state_q == S_INST);
   assign tw_vpn     = vpn_q;
   assign tw_frame   = frame_q;
   assign tw_vvec    = vvec_q;
   assign tw_rvec    = rvec_q;

   assign bs_valid   = c_hit || (state_q == S_BSET);
   assign bs_vpn     = vpn_q;
   assign bs_sub     = sub;
   assign bs_set_v   = (state_q == S_BSET);

   assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_hit, st_blk, st_vic, st_page}));

   assert_push_then_walk_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wbq_push |=> (pw_req && !pw_we));

   assert_block_fill_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && state_q == S_BFILL) |-> ($countones(fl_mask) == 1));

   assert_page_fill_has_sub_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && state_q == S_PFILL) |-> fl_mask[sub]);

   assert_closed_after_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      st_blk |=> !req_ready);

   assert_open_after_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> req_ready);

   assert_fresh_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tw_valid && $past(state_q) == S_PTEW) |-> (tw_rvec == '0));

   assert_victim_no_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      st_vic |=> !fl_req);

endmodule

// File: tb/fpmiss_ctrl_tb.sv
module fpmiss_ctrl_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic [19:0] lk_vpn;
   logic        lk_hit, lk_occ;
   logic [9:0]  lk_frame;
   logic [7:0]  lk_vvec, lk_vic_vvec, lk_vic_rvec;
   logic [19:0] lk_vic_vpn;
   logic        tw_valid;
   logic [19:0] tw_vpn;
   logic [9:0]  tw_frame;
   logic [7:0]  tw_vvec, tw_rvec;
   logic        bs_valid, bs_set_v;
   logic [19:0] bs_vpn;
   logic [2:0]  bs_sub;
   logic        resp_valid;
   logic [21:0] resp_caddr;
   logic        st_hit, st_blk, st_vic, st_page;
   logic        wbq_push;
   logic [19:0] wbq_vpn;
   logic [7:0]  wbq_vvec, wbq_rvec;
   logic        pw_req, pw_we;
   logic [19:0] pw_vpn;
   logic [63:0] pw_wdata;
   logic        pw_ack;
   logic [63:0] pw_rdata;
   logic        al_req, al_ack;
   logic [9:0]  al_frame;
   logic        fl_req, fl_done;
   logic [19:0] fl_ppn;
   logic [9:0]  fl_frame;
   logic [7:0]  fl_mask;
   logic        gt_req, gt_we, gt_ack;
   logic [9:0]  gt_frame;
   logic [19:0] gt_wppn, gt_wptr, gt_rppn;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpmiss_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_frame(lk_frame), .lk_vvec(lk_vvec), .lk_occ(lk_occ),
      .lk_vic_vpn(lk_vic_vpn), .lk_vic_vvec(lk_vic_vvec), .lk_vic_rvec(lk_vic_rvec),
      .tw_valid(tw_valid), .tw_vpn(tw_vpn), .tw_frame(tw_frame), .tw_vvec(tw_vvec), .tw_rvec(tw_rvec),
      .bs_valid(bs_valid), .bs_vpn(bs_vpn), .bs_sub(bs_sub), .bs_set_v(bs_set_v),
      .resp_valid(resp_valid), .resp_caddr(resp_caddr),
      .st_hit(st_hit), .st_blk(st_blk), .st_vic(st_vic), .st_page(st_page),
      .wbq_push(wbq_push), .wbq_vpn(wbq_vpn), .wbq_vvec(wbq_vvec), .wbq_rvec(wbq_rvec),
      .pw_req(pw_req), .pw_we(pw_we), .pw_vpn(pw_vpn), .pw_wdata(pw_wdata), .pw_ack(pw_ack), .pw_rdata(pw_rdata),
      .al_req(al_req), .al_ack(al_ack), .al_frame(al_frame),
      .fl_req(fl_req), .fl_ppn(fl_ppn), .fl_frame(fl_frame), .fl_mask(fl_mask), .fl_done(fl_done),
      .gt_req(gt_req), .gt_we(gt_we), .gt_frame(gt_frame), .gt_wppn(gt_wppn), .gt_wptr(gt_wptr),
      .gt_ack(gt_ack), .gt_rppn(gt_rppn)
   );

   // Environment models: 4-slot direct-mapped buffer, 16-entry page table, reverse table
   logic [63:0] pt_init [16];
   logic [63:0] pt      [16];
   logic        tv      [4];
   logic [19:0] ttag    [4];
   logic [9:0]  tfr     [4];
   logic [7:0]  tvv     [4];
   logic [7:0]  trv     [4];
   logic [19:0] g_ppn   [64];
   logic [19:0] g_ptr   [64];
   logic [9:0]  next_frame;

   always_comb begin
      lk_hit      = tv[lk_vpn[1:0]] && (ttag[lk_vpn[1:0]] == lk_vpn);
      lk_frame    = tfr[lk_vpn[1:0]];
      lk_vvec     = tvv[lk_vpn[1:0]];
      lk_occ      = tv[lk_vpn[1:0]];
      lk_vic_vpn  = ttag[lk_vpn[1:0]];
      lk_vic_vvec = tvv[lk_vpn[1:0]];
      lk_vic_rvec = trv[lk_vpn[1:0]];
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) pt[i] <= pt_init[i];
         for (int i = 0; i < 4; i++) begin
            tv[i] <= 1'b0; ttag[i] <= '0; tfr[i] <= '0; tvv[i] <= '0; trv[i] <= '0;
         end
         for (int i = 0; i < 64; i++) begin g_ppn[i] <= '0; g_ptr[i] <= '0; end
         next_frame <= 10'd0;
         pw_ack <= 1'b0; pw_rdata <= '0; al_ack <= 1'b0; al_frame <= '0;
         fl_done <= 1'b0; gt_ack <= 1'b0; gt_rppn <= '0;
      end else begin
         pw_ack  <= pw_req && !pw_ack;
         if (pw_req && !pw_ack) begin
            if (pw_we) pt[pw_vpn[3:0]] <= pw_wdata;
            else       pw_rdata <= pt[pw_vpn[3:0]];
         end
         al_ack <= al_req && !al_ack;
         if (al_req && !al_ack) begin
            al_frame   <= next_frame;
            next_frame <= next_frame + 10'd1;
         end
         fl_done <= fl_req && !fl_done;
         gt_ack  <= gt_req && !gt_ack;
         if (gt_req && !gt_ack) begin
            if (gt_we) begin
               g_ppn[gt_frame[5:0]] <= gt_wppn;
               g_ptr[gt_frame[5:0]] <= gt_wptr;
            end else gt_rppn <= g_ppn[gt_frame[5:0]];
         end
         if (tw_valid) begin
            tv[tw_vpn[1:0]]   <= 1'b1;
            ttag[tw_vpn[1:0]] <= tw_vpn;
            tfr[tw_vpn[1:0]]  <= tw_frame;
            tvv[tw_vpn[1:0]]  <= tw_vvec;
            trv[tw_vpn[1:0]]  <= tw_rvec;
         end
         if (bs_valid) begin
            if (bs_set_v) tvv[bs_vpn[1:0]][bs_sub] <= 1'b1;
            else          trv[bs_vpn[1:0]][bs_sub] <= 1'b1;
         end
         if (wbq_push) begin
            pt[wbq_vpn[3:0]][32 +: 8] <= wbq_rvec;
            pt[wbq_vpn[3:0]][48 +: 8] <= wbq_vvec;
         end
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic access(input logic [31:0] va);
      logic [19:0] vpn;
      logic [2:0]  sub;
      logic [11:0] off;
      logic [1:0]  sl;
      logic [7:0]  oh, e_mask, last_mask;
      logic [9:0]  f;
      logic [19:0] ppn;
      logic [63:0] pte, e_pte;
      logic [21:0] caddr;
      bit thit, e_push, e_vic, e_page, e_blk, e_hist, done, busy_bad;
      int e_fills, n_hit, n_blk, n_vic, n_page, n_push, n_fill, multi, cyc;
      vpn = va[31:12]; sub = va[11:9]; off = va[11:0]; sl = vpn[1:0];
      oh = 8'b1 << sub;
      e_push = 0; e_vic = 0; e_page = 0; e_blk = 0; e_fills = 0; e_mask = '0;
      e_hist = 0; ppn = '0; f = '0;
      thit = tv[sl] && (ttag[sl] == vpn);
      if (thit) begin
         f = tfr[sl];
         e_blk = !tvv[sl][sub];
      end else begin
         e_push = tv[sl];
         pte = pt[vpn[3:0]];
         if (pte[0]) begin
            e_vic = 1; f = pte[2 +: 10]; e_blk = !pte[48 + int'(sub)];
         end else begin
            e_page = 1; f = next_frame; e_hist = pte[1];
            e_mask = (pte[1] ? pte[32 +: 8] : 8'hFF) | oh;
            ppn = pte[2 +: 20]; e_fills = 1;
         end
      end
      if (e_blk) begin e_fills = 1; e_mask = oh; end

      @(negedge clk);
      req_valid = 1'b1; req_va = va;
      @(negedge clk);
      req_valid = 1'b0;
      n_hit = 0; n_blk = 0; n_vic = 0; n_page = 0; n_push = 0; n_fill = 0; multi = 0;
      done = 0; busy_bad = 0; cyc = 0; last_mask = '0; caddr = '0;
      while (!done && cyc < 200) begin
         n_hit  += int'(st_hit);  n_blk  += int'(st_blk);
         n_vic  += int'(st_vic);  n_page += int'(st_page);
         n_push += int'(wbq_push);
         if ($countones({st_hit, st_blk, st_vic, st_page}) > 1) multi++;
         if (fl_req && fl_done) begin n_fill++; last_mask = fl_mask; end
         if (resp_valid) begin done = 1; caddr = resp_caddr; end
         else begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            cyc++;
         end
      end
      check(done, "R10", "access completion", 64'(done), 64'd1);
      check(n_hit == 1, "R10", "hit pulses", 64'(n_hit), 64'd1);
      check(multi == 0, "R10", "overlapping pulses", 64'(multi), 64'd0);
      check(n_blk == int'(e_blk), "R3", "block-miss pulses", 64'(n_blk), 64'(e_blk));
      check(n_vic == int'(e_vic), "R5", "victim-hit pulses", 64'(n_vic), 64'(e_vic));
      check(n_page == int'(e_page), "R6", "page-miss pulses", 64'(n_page), 64'(e_page));
      check(n_push == int'(e_push), "R4", "queue pushes", 64'(n_push), 64'(e_push));
      check(n_fill == e_fills, e_vic ? "R5" : "R3", "fill count", 64'(n_fill), 64'(e_fills));
      if (e_fills > 0 && n_fill > 0)
         check(last_mask == e_mask, e_blk ? "R3" : (e_hist ? "R6" : "R7"), "fill mask",
               64'(last_mask), 64'(e_mask));
      check(caddr == {f, off}, "R2", "cache address", 64'(caddr), 64'({f, off}));
      check(!busy_bad, "R9", "ready low while busy", 64'(busy_bad), 64'd0);
      @(negedge clk);
      check(req_ready, "R9", "ready after hit", 64'(req_ready), 64'd1);
      check(trv[sl][sub], "R2", "reference bit set", 64'(trv[sl]), 64'(oh));
      check(tvv[sl][sub], "R3", "valid bit set", 64'(tvv[sl]), 64'(oh));
      if (e_page) begin
         e_pte = '0; e_pte[0] = 1'b1; e_pte[1] = 1'b1; e_pte[2 +: 20] = 20'(f);
         e_pte[48 +: 8] = e_mask;
         check(pt[vpn[3:0]] == e_pte, "R8", "rewritten entry", pt[vpn[3:0]], e_pte);
         check(g_ppn[f[5:0]] == ppn, "R8", "reverse ppn", 64'(g_ppn[f[5:0]]), 64'(ppn));
         check(g_ptr[f[5:0]] == vpn, "R8", "reverse pointer", 64'(g_ptr[f[5:0]]), 64'(vpn));
         check(trv[sl] == oh, "R8", "installed reference vector", 64'(trv[sl]), 64'(oh));
         check(tvv[sl] == e_mask, "R8", "installed valid vector", 64'(tvv[sl]), 64'(e_mask));
      end
   endtask

   initial begin
      void'($urandom(32'd20251));
      for (int i = 0; i < 16; i++) begin
         pt_init[i] = '0;
         pt_init[i][2 +: 20] = 20'(100 + i);
         if (i >= 8) begin
            pt_init[i][1] = 1'b1;
            pt_init[i][32 +: 8] = 8'($urandom);
         end
      end
      pt_init[9][32 +: 8] = 8'b0000_0110;

      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: idle outputs while in reset and right after
      check(req_ready, "R1", "ready in reset", 64'(req_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready, "R1", "ready after reset", 64'(req_ready), 64'd1);
      check({st_hit, st_blk, st_vic, st_page} == 4'b0, "R1", "status pulses",
            64'({st_hit, st_blk, st_vic, st_page}), 64'd0);
      check({pw_req, al_req, fl_req, gt_req, tw_valid, wbq_push, bs_valid} == 7'b0, "R1",
            "port requests", 64'({pw_req, al_req, fl_req, gt_req, tw_valid, wbq_push, bs_valid}), 64'd0);

      access({20'd1, 3'd3, 9'h011});  // R7 first touch, full page
      access({20'd1, 3'd5, 9'h022});  // R2 plain hit
      access({20'd9, 3'd0, 9'h033});  // R6 history fill, R4 push of page 1
      access({20'd9, 3'd5, 9'h044});  // R3 block miss
      access({20'd1, 3'd2, 9'h055});  // R5 victim hit, R4 push of page 9
      access({20'd9, 3'd7, 9'h066});  // R5 victim with restored vectors

      for (int k = 0; k < 400; k++) begin
         logic [31:0] va;
         va = $urandom;
         va[31:12] = 20'($urandom_range(0, 15));
         access(va);
      end
      finish_run();
   end

endmodule